// File: doc/BRIEF.md
# Circular Control-Transfer Record Buffer

This block is the storage half of a control-transfer history facility. A separate qualification stage decides which transfers are worth keeping and presents each one on a one-cycle record strobe. The record carries a source PC, a target PC, a mispredict flag, a transfer kind and a metadata word. The buffer places it in a ring of physical slots at the write pointer. Software sees the ring through a single access port addressed by logical index, where index 0 is always the youngest record. The block turns that index into a physical slot by counting back from the write pointer.

Software picks the active depth (16 to 256 entries, bounded by the largest depth built in). It can read and load the write pointer, overwrite any logical entry in place, and wipe the whole store with a one-cycle clear. A return-stack emulation mode changes how records are taken. Calls push as usual, returns pop the youngest record and invalidate it, co-routine swaps replace the youngest record, and every other kind is dropped. This keeps the ring a picture of the live call stack.

Top module: `xfer_hist_buf`

## Requirements
- R1: After reset `ptrOut` is 0 and every logical index reads 0 on `rdSrc`, `rdTgt` and `rdMeta`.
- R2: The active depth is 16 << `depthCode`. A code above parameter `MAX_DEPTH_CODE`, including the reserved codes 6 and 7, behaves as `MAX_DEPTH_CODE`.
- R3: Logical index X below the depth addresses physical slot (pointer − X − 1) mod depth. An index at or above the depth reads 0 on all three outputs, and a write to it changes nothing.
- R4: With `rasMode` low, every `recValid` cycle stores `recSrc` with bit 0 forced to 1 (valid), `recTgt` with bit 0 replaced by `recMisp`, and `recMeta` at the pointer. The pointer then advances by one and wraps from depth−1 to 0, so a full ring loses its oldest record.
- R5: With `rasMode` high, a record of kind 13 (return) moves the pointer back by one, wrapping from 0 to depth−1. It then clears bit 0 of the slot now pointed at. Logical 0 then shows the former logical 1, and logical depth−1 shows the popped record with bit 0 low.
- R6: With `rasMode` high, kinds 8 and 9 (calls) are recorded as in R4. Kind 12 (co-routine swap) overwrites logical 0 and leaves the pointer unchanged. Every other kind leaves the store and pointer untouched.
- R7: `ptrOut` bits above those needed for depth−1 read 0, including right after the depth is lowered.
- R8: `clrCmd` zeroes every slot for all depths and leaves the pointer as it was. A record or entry write in the same cycle is dropped.
- R9: `ptrWe` loads `ptrWrData` (masked to the depth) into the pointer, unless a record is taken in the same cycle. In that case the hardware update wins.
- R10: `swWe` overwrites source, target and metadata of the addressed logical entry with the given words and never moves the pointer. It is dropped when a record is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| depthCode | input | 3 | Depth selection code |
| rasMode | input | 1 | Return-stack emulation enable |
| recValid | input | 1 | Qualified transfer strobe |
| recKind | input | 4 | Transfer kind code |
| recSrc | input | PC_W | Source PC (bit 0 ignored) |
| recTgt | input | PC_W | Target PC (bit 0 ignored) |
| recMisp | input | 1 | Mispredict flag |
| recMeta | input | META_W | Metadata word |
| swIdx | input | 8 | Logical index for access |
| swWe | input | 1 | Entry write strobe |
| swSrcWr | input | PC_W | Source word to write, bit 0 is valid |
| swTgtWr | input | PC_W | Target word to write, bit 0 is mispredict |
| swMetaWr | input | META_W | Metadata word to write |
| rdSrc | output | PC_W | Source word at logical index |
| rdTgt | output | PC_W | Target word at logical index |
| rdMeta | output | META_W | Metadata at logical index |
| ptrWe | input | 1 | Pointer load strobe |
| ptrWrData | input | 8 | Pointer load value |
| ptrOut | output | 8 | Current write pointer |
| clrCmd | input | 1 | Clear all entries |

## Verification
The bench builds the block with `MAX_DEPTH_CODE` = 1, so the ring holds 32 physical slots and the 16- and 32-entry depths can both be selected. Both wrap-arounds can be forced in a few dozen records. With that setting, codes 2 through 7 fall into the clamped range, and lowering the depth from 32 to 16 with the pointer above 15 exposes the masking of high pointer bits. `PC_W` = 32 and `META_W` = 16 keep expected words easy to derive from a seed byte.

// File: rtl/xfer_hist_pkg.sv
package xfer_hist_pkg;

  localparam int SLOT_W = 8;

  localparam logic [3:0] KIND_CALL_IND = 4'd8;
  localparam logic [3:0] KIND_CALL_DIR = 4'd9;
  localparam logic [3:0] KIND_SWAP     = 4'd12;
  localparam logic [3:0] KIND_RET      = 4'd13;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic              clrAll;
    logic              wrEn;
    logic              wrHw;
    logic [SLOT_W-1:0] wrSlot;
    logic              invEn;
    logic [SLOT_W-1:0] invSlot;
  } ringStrobe_t;

endpackage

// File: rtl/xfer_hist_ctrl.sv
module xfer_hist_ctrl
  import xfer_hist_pkg::*;
#(
  parameter int MAX_DEPTH_CODE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        depthCode,
  input  logic              rasMode,
  input  logic              recValid,
  input  logic [3:0]        recKind,
  input  logic [SLOT_W-1:0] swIdx,
  input  logic              swWe,
  input  logic              ptrWe,
  input  logic [SLOT_W-1:0] ptrWrData,
  input  logic              clrCmd,
  output ringStrobe_t       strobe,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              rdInRange,
  output logic [SLOT_W-1:0] ptrOut
);

  localparam logic [2:0] MAX_CODE = 3'(MAX_DEPTH_CODE);

  logic [2:0]        effCode;
  logic [SLOT_W:0]   depthN;
  logic [SLOT_W-1:0] depthMask;
  logic [SLOT_W-1:0] wrPtr;
  logic [SLOT_W-1:0] ptrCur;
  logic [SLOT_W-1:0] ptrInc;
  logic [SLOT_W-1:0] ptrDec;
  logic [SLOT_W-1:0] ptrNext;
  logic [SLOT_W-1:0] swPhys;
  logic              isCall;
  logic              isRet;
  logic              isSwap;
  logic              doRec;
  logic              doPush;
  logic              doPop;
  logic              doSwap;
  logic              swOk;
  logic              swInRange;

  // Depth selection: clamp unsupported and reserved codes to the built maximum.
  always_comb begin
    effCode   = (depthCode > MAX_CODE) ? MAX_CODE : depthCode;
    depthN    = (SLOT_W+1)'(16) << effCode;
    depthMask = SLOT_W'(depthN - (SLOT_W+1)'(1));
  end

  assign ptrCur = wrPtr & depthMask;
  assign ptrInc = (ptrCur + SLOT_W'(1)) & depthMask;
  assign ptrDec = (ptrCur - SLOT_W'(1)) & depthMask;

  // Transfer classification.
  assign isCall = (recKind == KIND_CALL_IND) || (recKind == KIND_CALL_DIR);
  assign isRet  = (recKind == KIND_RET);
  assign isSwap = (recKind == KIND_SWAP);

  assign doRec  = recValid && !clrCmd && (!rasMode || isCall || isRet || isSwap);
  assign doPop  = doRec && rasMode && isRet;
  assign doSwap = doRec && rasMode && isSwap;
  assign doPush = doRec && !doPop && !doSwap;

  // Logical-to-physical mapping for the software port.
  assign swInRange = ({1'b0, swIdx} < depthN);
  assign swPhys    = (ptrCur - swIdx - SLOT_W'(1)) & depthMask;
  assign swOk      = swWe && swInRange && !doRec && !clrCmd;

  always_comb begin
    strobe.clrAll  = clrCmd;
    strobe.wrEn    = doPush || doSwap || swOk;
    strobe.wrHw    = doPush || doSwap;
    strobe.invEn   = doPop;
    strobe.invSlot = ptrDec;
    if (doPush)      strobe.wrSlot = ptrCur;
    else if (doSwap) strobe.wrSlot = ptrDec;
    else             strobe.wrSlot = swPhys;
  end

  // Pointer update: hardware movement beats a software load.
  always_comb begin
    if (doPush)              ptrNext = ptrInc;
    else if (doPop)          ptrNext = ptrDec;
    else if (ptrWe && !doRec) ptrNext = ptrWrData & depthMask;
    else                     ptrNext = ptrCur;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrPtr <= '0;
    else       wrPtr <= ptrNext;
  end

  assign rdSlot    = swPhys;
  assign rdInRange = swInRange;
  assign ptrOut    = ptrCur;

endmodule

// File: rtl/xfer_hist_store.sv
module xfer_hist_store
  import xfer_hist_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int META_W = 16,
  parameter int NUM    = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [PC_W-1:0]   hwSrc,
  input  logic [PC_W-1:0]   hwTgt,
  input  logic [META_W-1:0] hwMeta,
  input  logic [PC_W-1:0]   swSrc,
  input  logic [PC_W-1:0]   swTgt,
  input  logic [META_W-1:0] swMeta,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [PC_W-1:0]   rdSrcRaw,
  output logic [PC_W-1:0]   rdTgtRaw,
  output logic [META_W-1:0] rdMetaRaw
);

  localparam int AW = $clog2(NUM);

  logic [PC_W-1:0]   srcMem  [NUM];
  logic [PC_W-1:0]   tgtMem  [NUM];
  logic [META_W-1:0] metaMem [NUM];
  logic [PC_W-1:0]   wSrc;
  logic [PC_W-1:0]   wTgt;
  logic [META_W-1:0] wMeta;
  logic [NUM-1:0]    wrHit;
  logic [NUM-1:0]    invHit;

  assign wSrc  = strobe.wrHw ? hwSrc  : swSrc;
  assign wTgt  = strobe.wrHw ? hwTgt  : swTgt;
  assign wMeta = strobe.wrHw ? hwMeta : swMeta;

  // Per-slot select decode.
  for (genvar g = 0; g < NUM; g++) begin : g_hit
    assign wrHit[g]  = strobe.wrEn  && (strobe.wrSlot[AW-1:0]  == AW'(g));
    assign invHit[g] = strobe.invEn && (strobe.invSlot[AW-1:0] == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (!rstN || strobe.clrAll) begin
        srcMem[i]  <= '0;
        tgtMem[i]  <= '0;
        metaMem[i] <= '0;
      end else if (wrHit[i]) begin
        srcMem[i]  <= wSrc;
        tgtMem[i]  <= wTgt;
        metaMem[i] <= wMeta;
      end else if (invHit[i]) begin
        srcMem[i][0] <= 1'b0;
      end
    end
  end

  assign rdSrcRaw  = srcMem[rdSlot[AW-1:0]];
  assign rdTgtRaw  = tgtMem[rdSlot[AW-1:0]];
  assign rdMetaRaw = metaMem[rdSlot[AW-1:0]];

  logic unusedSlotHi;
  if (AW < SLOT_W) begin : g_unusedHi
    assign unusedSlotHi = ^{rdSlot[SLOT_W-1:AW], strobe.wrSlot[SLOT_W-1:AW],
                            strobe.invSlot[SLOT_W-1:AW]};
  end else begin : g_noHi
    assign unusedSlotHi = 1'b0;
  end

endmodule

// File: rtl/xfer_hist_buf.sv
module xfer_hist_buf
  import xfer_hist_pkg::*;
#(
  parameter int PC_W           = 32,
  parameter int META_W         = 16,
  parameter int MAX_DEPTH_CODE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        depthCode,
  input  logic              rasMode,
  input  logic              recValid,
  input  logic [3:0]        recKind,
  input  logic [PC_W-1:0]   recSrc,
  input  logic [PC_W-1:0]   recTgt,
  input  logic              recMisp,
  input  logic [META_W-1:0] recMeta,
  input  logic [7:0]        swIdx,
  input  logic              swWe,
  input  logic [PC_W-1:0]   swSrcWr,
  input  logic [PC_W-1:0]   swTgtWr,
  input  logic [META_W-1:0] swMetaWr,
  output logic [PC_W-1:0]   rdSrc,
  output logic [PC_W-1:0]   rdTgt,
  output logic [META_W-1:0] rdMeta,
  input  logic              ptrWe,
  input  logic [7:0]        ptrWrData,
  output logic [7:0]        ptrOut,
  input  logic              clrCmd
);

  localparam int NUM = 16 << MAX_DEPTH_CODE;

  ringStrobe_t       strobe;
  logic [SLOT_W-1:0] rdSlot;
  logic              rdInRange;
  logic [PC_W-1:0]   rdSrcRaw;
  logic [PC_W-1:0]   rdTgtRaw;
  logic [META_W-1:0] rdMetaRaw;
  logic              unusedPcLsb;

  assign unusedPcLsb = recSrc[0] ^ recTgt[0];

  xfer_hist_ctrl #(.MAX_DEPTH_CODE(MAX_DEPTH_CODE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .depthCode (depthCode),
    .rasMode   (rasMode),
    .recValid  (recValid),
    .recKind   (recKind),
    .swIdx     (swIdx),
    .swWe      (swWe),
    .ptrWe     (ptrWe),
    .ptrWrData (ptrWrData),
    .clrCmd    (clrCmd),
    .strobe    (strobe),
    .rdSlot    (rdSlot),
    .rdInRange (rdInRange),
    .ptrOut    (ptrOut)
  );

  xfer_hist_store #(.PC_W(PC_W), .META_W(META_W), .NUM(NUM)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hwSrc     ({recSrc[PC_W-1:1], 1'b1}),
    .hwTgt     ({recTgt[PC_W-1:1], recMisp}),
    .hwMeta    (recMeta),
    .swSrc     (swSrcWr),
    .swTgt     (swTgtWr),
    .swMeta    (swMetaWr),
    .rdSlot    (rdSlot),
    .rdSrcRaw  (rdSrcRaw),
    .rdTgtRaw  (rdTgtRaw),
    .rdMetaRaw (rdMetaRaw)
  );

  assign rdSrc  = rdInRange ? rdSrcRaw  : '0;
  assign rdTgt  = rdInRange ? rdTgtRaw  : '0;
  assign rdMeta = rdInRange ? rdMetaRaw : '0;

endmodule

// File: rtl/xfer_hist_chk.sv
module xfer_hist_chk #(
  parameter int PC_W           = 32,
  parameter int META_W         = 16,
  parameter int MAX_DEPTH_CODE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        depthCode,
  input logic              rasMode,
  input logic              recValid,
  input logic [3:0]        recKind,
  input logic [PC_W-1:0]   recSrc,
  input logic [7:0]        swIdx,
  input logic              swWe,
  input logic              ptrWe,
  input logic              clrCmd,
  input logic [PC_W-1:0]   rdSrc,
  input logic [PC_W-1:0]   rdTgt,
  input logic [META_W-1:0] rdMeta,
  input logic [7:0]        ptrOut
);

  logic [8:0] ckDepth;
  logic [7:0] ckMask;
  logic       unusedLsb;

  assign unusedLsb = recSrc[0];

  always_comb begin
    if (int'(depthCode) > MAX_DEPTH_CODE) ckDepth = 9'(16 << MAX_DEPTH_CODE);
    else                                   ckDepth = 9'(16) << depthCode;
    ckMask = 8'(ckDepth - 9'd1);
  end

  // R4: a normal record advances the pointer by one, modulo the depth
  assert_push_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !rasMode && !clrCmd) |=>
      (depthCode != $past(depthCode)) || (ptrOut == (($past(ptrOut) + 8'd1) & ckMask)));

  // R4: the youngest logical entry holds the record just taken, marked valid
  assert_push_youngest_R4: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !rasMode && !clrCmd) |=>
      (depthCode != $past(depthCode)) || (swIdx != 8'd0) ||
      (rdSrc == {$past(recSrc[PC_W-1:1]), 1'b1}));

  // R5: a return in emulation mode moves the pointer back, modulo the depth
  assert_pop_retreat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && rasMode && recKind == 4'd13 && !clrCmd) |=>
      (depthCode != $past(depthCode)) || (ptrOut == (($past(ptrOut) - 8'd1) & ckMask)));

  // R3: indices at or above the depth read zero
  assert_oor_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, swIdx} >= ckDepth) |-> (rdSrc == '0 && rdTgt == '0 && rdMeta == '0));

  // R7: pointer never exceeds depth-1
  assert_ptr_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ptrOut & ~ckMask) == 8'd0));

  // R8: after a clear every index reads zero
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrCmd |=> (rdSrc == '0 && rdTgt == '0 && rdMeta == '0));

  // R10: an entry write alone never moves the pointer
  assert_swwr_ptr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swWe && !recValid && !ptrWe && !clrCmd) |=>
      (depthCode != $past(depthCode)) || (ptrOut == $past(ptrOut)));

endmodule

bind xfer_hist_buf xfer_hist_chk #(
  .PC_W(PC_W), .META_W(META_W), .MAX_DEPTH_CODE(MAX_DEPTH_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .depthCode(depthCode), .rasMode(rasMode),
  .recValid(recValid), .recKind(recKind), .recSrc(recSrc), .swIdx(swIdx),
  .swWe(swWe), .ptrWe(ptrWe), .clrCmd(clrCmd), .rdSrc(rdSrc), .rdTgt(rdTgt),
  .rdMeta(rdMeta), .ptrOut(ptrOut)
);

// File: tb/xfer_hist_buf_bench.sv
`timescale 1ns/1ps
module xfer_hist_buf_bench;

  localparam int PC_W = 32;
  localparam int META_W = 16;
  localparam int MAXC = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] depthCode = 3'd0;
  logic rasMode = 1'b0;
  logic recValid = 1'b0;
  logic [3:0] recKind = 4'd0;
  logic [PC_W-1:0] recSrc = '0;
  logic [PC_W-1:0] recTgt = '0;
  logic recMisp = 1'b0;
  logic [META_W-1:0] recMeta = '0;
  logic [7:0] swIdx = 8'd0;
  logic swWe = 1'b0;
  logic [PC_W-1:0] swSrcWr = '0;
  logic [PC_W-1:0] swTgtWr = '0;
  logic [META_W-1:0] swMetaWr = '0;
  logic [PC_W-1:0] rdSrc;
  logic [PC_W-1:0] rdTgt;
  logic [META_W-1:0] rdMeta;
  logic ptrWe = 1'b0;
  logic [7:0] ptrWrData = 8'd0;
  logic [7:0] ptrOut;
  logic clrCmd = 1'b0;

  always #2.5 clk = ~clk;

  xfer_hist_buf #(.PC_W(PC_W), .META_W(META_W), .MAX_DEPTH_CODE(MAXC)) u_xfer_hist_buf (
    .clk(clk), .rstN(rstN), .depthCode(depthCode), .rasMode(rasMode),
    .recValid(recValid), .recKind(recKind), .recSrc(recSrc), .recTgt(recTgt),
    .recMisp(recMisp), .recMeta(recMeta), .swIdx(swIdx), .swWe(swWe),
    .swSrcWr(swSrcWr), .swTgtWr(swTgtWr), .swMetaWr(swMetaWr),
    .rdSrc(rdSrc), .rdTgt(rdTgt), .rdMeta(rdMeta), .ptrWe(ptrWe),
    .ptrWrData(ptrWrData), .ptrOut(ptrOut), .clrCmd(clrCmd)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Logical-order reference model (index 0 = youngest).
  logic [PC_W-1:0] mSrc [32];
  logic [PC_W-1:0] mTgt [32];
  logic [META_W-1:0] mMeta [32];
  int mDepth = 16;
  int mPtr = 0;

  function automatic logic [PC_W-1:0] srcOf(input logic [7:0] s);
    return 32'h1000_0000 + {22'd0, s, 2'b00};
  endfunction
  function automatic logic [PC_W-1:0] tgtOf(input logic [7:0] s);
    return 32'h2000_0000 + {21'd0, s, 3'b000};
  endfunction
  function automatic logic [META_W-1:0] metaOf(input logic [7:0] s);
    return {8'hA0, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelPush(input logic [7:0] s);
    for (int x = mDepth - 1; x > 0; x--) begin
      mSrc[x] = mSrc[x-1]; mTgt[x] = mTgt[x-1]; mMeta[x] = mMeta[x-1];
    end
    mSrc[0] = srcOf(s) | 32'd1;
    mTgt[0] = tgtOf(s) | {31'd0, s[0]};
    mMeta[0] = metaOf(s);
    mPtr = (mPtr + 1) % mDepth;
  endtask

  task automatic modelPop();
    logic [PC_W-1:0] ts; logic [PC_W-1:0] tt; logic [META_W-1:0] tm;
    ts = mSrc[0]; tt = mTgt[0]; tm = mMeta[0];
    for (int x = 0; x < mDepth - 1; x++) begin
      mSrc[x] = mSrc[x+1]; mTgt[x] = mTgt[x+1]; mMeta[x] = mMeta[x+1];
    end
    mSrc[mDepth-1] = ts & ~32'd1; mTgt[mDepth-1] = tt; mMeta[mDepth-1] = tm;
    mPtr = (mPtr + mDepth - 1) % mDepth;
  endtask

  // Drive one record for one cycle; results visible at the following negedge.
  task automatic rec(input logic ras, input logic [3:0] k, input logic [7:0] s);
    @(negedge clk);
    rasMode = ras; recKind = k; recSrc = srcOf(s); recTgt = tgtOf(s);
    recMisp = s[0]; recMeta = metaOf(s); recValid = 1'b1;
    @(negedge clk);
    recValid = 1'b0; rasMode = 1'b0;
  endtask

  task automatic rdAt(input logic [7:0] idx);
    swIdx = idx;
    #0.5;
  endtask

  task automatic chkModel(input string req, input int upto);
    for (int x = 0; x < upto; x++) begin
      rdAt(8'(x));
      chk(req, rdSrc, mSrc[x]);
      if (x == 0) begin
        chk(req, rdTgt, mTgt[0]);
        chk(req, {16'd0, rdMeta}, {16'd0, mMeta[0]});
      end
    end
    chk(req, {24'd0, ptrOut}, 32'(mPtr));
  endtask

  // Step table: {ras, kind, seed}
  localparam int NSTEP = 16;
  localparam logic [12:0] STEP_TBL [NSTEP] = '{
    {1'b0, 4'd5,  8'h01}, {1'b0, 4'd9,  8'h02}, {1'b0, 4'd1,  8'h03},
    {1'b0, 4'd13, 8'h04}, {1'b1, 4'd9,  8'h05}, {1'b1, 4'd8,  8'h06},
    {1'b1, 4'd13, 8'h00}, {1'b1, 4'd12, 8'h07}, {1'b1, 4'd5,  8'h08},
    {1'b1, 4'd13, 8'h00}, {1'b1, 4'd13, 8'h00}, {1'b0, 4'd4,  8'h09},
    {1'b1, 4'd15, 8'h0A}, {1'b0, 4'd12, 8'h0B}, {1'b1, 4'd9,  8'h0C},
    {1'b1, 4'd13, 8'h00}
  };

  initial begin
    for (int x = 0; x < 32; x++) begin mSrc[x] = '0; mTgt[x] = '0; mMeta[x] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkModel("R1 reset", 16);
    rdAt(8'd31); chk("R1 reset idx31", rdSrc, 32'd0);

    // R4 R5 R6: table walk
    for (int st = 0; st < NSTEP; st++) begin
      logic ras; logic [3:0] k; logic [7:0] s;
      {ras, k, s} = STEP_TBL[st];
      rec(ras, k, s);
      if (!ras) modelPush(s);
      else if (k == 4'd8 || k == 4'd9) modelPush(s);
      else if (k == 4'd13) modelPop();
      else if (k == 4'd12) begin
        mSrc[0] = srcOf(s) | 32'd1; mTgt[0] = tgtOf(s) | {31'd0, s[0]}; mMeta[0] = metaOf(s);
      end
      chkModel(ras ? "R5/R6 emulation step" : "R4 record step", 4);
    end
    chkModel("R5 invalid slots after pops", 16);

    // R4: wrap and overwrite of oldest
    for (int i = 0; i < 20; i++) begin
      rec(1'b0, 4'd5, 8'(8'h20 + i));
      modelPush(8'(8'h20 + i));
    end
    chkModel("R4 wrap", 16);

    // R10: software entry write in place
    @(negedge clk);
    swIdx = 8'd2; swSrcWr = 32'hDEAD_0000; swTgtWr = 32'hBEEF_0001; swMetaWr = 16'h5A5A; swWe = 1'b1;
    @(negedge clk);
    swWe = 1'b0;
    mSrc[2] = 32'hDEAD_0000; mTgt[2] = 32'hBEEF_0001; mMeta[2] = 16'h5A5A;
    rdAt(8'd2);
    chk("R10 entry write tgt", rdTgt, 32'hBEEF_0001);
    chk("R10 entry write meta", {16'd0, rdMeta}, 32'h5A5A);
    chkModel("R10 entry write src/ptr", 16);

    // R3: out-of-range write ignored and read zero
    @(negedge clk);
    swIdx = 8'd16; swSrcWr = 32'h1111_1111; swTgtWr = 32'h2222_2222; swMetaWr = 16'h3333; swWe = 1'b1;
    @(negedge clk);
    swWe = 1'b0;
    rdAt(8'd16);
    chk("R3 oor src", rdSrc, 32'd0);
    chk("R3 oor tgt", rdTgt, 32'd0);
    chk("R3 oor meta", {16'd0, rdMeta}, 32'd0);
    chkModel("R3 oor write ignored", 16);

    // R10: entry write dropped when a record lands in the same cycle
    @(negedge clk);
    swIdx = 8'd0; swSrcWr = 32'h7777_0000; swWe = 1'b1;
    rasMode = 1'b0; recKind = 4'd5; recSrc = srcOf(8'h50); recTgt = tgtOf(8'h50);
    recMisp = 1'b0; recMeta = metaOf(8'h50); recValid = 1'b1;
    @(negedge clk);
    swWe = 1'b0; recValid = 1'b0;
    modelPush(8'h50);
    chkModel("R10 collision record wins", 16);

    // R9: pointer load loses to a same-cycle record
    @(negedge clk);
    ptrWe = 1'b1; ptrWrData = 8'd9;
    recKind = 4'd5; recSrc = srcOf(8'h51); recTgt = tgtOf(8'h51);
    recMisp = 1'b1; recMeta = metaOf(8'h51); recValid = 1'b1;
    @(negedge clk);
    ptrWe = 1'b0; recValid = 1'b0;
    modelPush(8'h51);
    chkModel("R9 record beats pointer load", 1);

    // R9: plain pointer load, masked to depth 16
    @(negedge clk);
    ptrWe = 1'b1; ptrWrData = 8'h23;
    @(negedge clk);
    ptrWe = 1'b0;
    #0.5; chk("R9 pointer load masked", {24'd0, ptrOut}, 32'd3);

    // R8: clear, pointer kept, reads zero at every index of the larger depth
    @(negedge clk);
    clrCmd = 1'b1;
    @(negedge clk);
    clrCmd = 1'b0;
    depthCode = 3'd1;
    #0.5; chk("R8 clear keeps pointer", {24'd0, ptrOut}, 32'd3);
    for (int x = 0; x < 32; x++) begin
      rdAt(8'(x));
      chk("R8 clear zero", rdSrc | rdTgt | {16'd0, rdMeta}, 32'd0);
    end
    // R8: clear beats a same-cycle record
    @(negedge clk);
    clrCmd = 1'b1; recKind = 4'd5; recSrc = srcOf(8'h60); recValid = 1'b1;
    @(negedge clk);
    clrCmd = 1'b0; recValid = 1'b0;
    rdAt(8'd0);
    chk("R8 clear drops record src", rdSrc, 32'd0);
    chk("R8 clear drops record ptr", {24'd0, ptrOut}, 32'd3);

    // R2 R7: depth 32, clamp of high codes, lowering the depth
    @(negedge clk);
    ptrWe = 1'b1; ptrWrData = 8'd0;
    @(negedge clk);
    ptrWe = 1'b0;
    for (int i = 0; i < 20; i++) rec(1'b0, 4'd11, 8'(8'h40 + i));
    #0.5; chk("R2 depth 32 pointer", {24'd0, ptrOut}, 32'd20);
    rdAt(8'd19);
    chk("R2 depth 32 oldest", rdSrc, srcOf(8'h40) | 32'd1);
    depthCode = 3'd7;
    rdAt(8'd19);
    chk("R2 reserved code clamps", rdSrc, srcOf(8'h40) | 32'd1);
    depthCode = 3'd2;
    rdAt(8'd25);
    chk("R2 unsupported code clamps idx25", rdSrc, 32'd0);
    #0.5; chk("R2 unsupported code pointer", {24'd0, ptrOut}, 32'd20);
    depthCode = 3'd0;
    #0.5; chk("R7 pointer high bits", {24'd0, ptrOut}, 32'd4);
    rdAt(8'd19);
    chk("R3 idx beyond 16 zero", rdSrc, 32'd0);
    rdAt(8'd0);
    chk("R3 mapping after depth drop", rdSrc, srcOf(8'h43) | 32'd1);
    chk("R4 mispredict bit", rdTgt, tgtOf(8'h43) | 32'd1);

    // R5: return wraps the pointer from 0 to depth-1
    @(negedge clk);
    ptrWe = 1'b1; ptrWrData = 8'd0;
    @(negedge clk);
    ptrWe = 1'b0;
    rec(1'b1, 4'd13, 8'h00);
    #0.5; chk("R5 pop wraps pointer", {24'd0, ptrOut}, 32'd15);
    rdAt(8'd15);
    chk("R5 popped slot invalid", rdSrc, srcOf(8'h4F));
    // R6: swap keeps pointer and replaces logical 0
    rec(1'b1, 4'd12, 8'h70);
    #0.5; chk("R6 swap keeps pointer", {24'd0, ptrOut}, 32'd15);
    rdAt(8'd0);
    chk("R6 swap overwrites youngest", rdSrc, srcOf(8'h70) | 32'd1);
    // R6: non-call kind ignored in emulation mode
    rec(1'b1, 4'd1, 8'h71);
    #0.5; chk("R6 other kind ignored ptr", {24'd0, ptrOut}, 32'd15);
    chk("R6 other kind ignored data", rdSrc, srcOf(8'h70) | 32'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule